// File: doc/BRIEF.md
# Real-Time Clock Event Interrupt and Wake-Up Controller

This block turns two kinds of clock events into interrupt and wake-up requests. An alarm-match pulse and a periodic tick are each captured into a sticky flag bit. The tick is derived from a 128 Hz base pulse through a divider whose rate is chosen by a 3-bit selector. Software clears a flag by writing 1 to its bit and gates each flag onto a single interrupt line with a per-event enable bit.

While the chip is in power-down, a small state machine raises a wake-up request. An alarm match always wakes the chip. A tick wakes it only when a separate tick wake-up enable is set. The request is a level. It stays high until the power-down input falls.

The wake state machine has three states. AWAKE means the chip is running. ASLEEP means power-down is active and no wake event has arrived yet. WAKING means the wake request is asserted. The transitions are:
- GO_SLEEP: AWAKE to ASLEEP when power-down is high and there is no wake event.
- DIRECT_WAKE: AWAKE to WAKING when power-down is high and a wake event arrives in the same cycle.
- WAKE_HIT: ASLEEP to WAKING on a wake event while power-down is high.
- ABORT_SLEEP: ASLEEP to AWAKE when power-down falls.
- RESUME: WAKING to AWAKE when power-down falls.

Top module: `rtc_evt_wake_ctrl`

## Requirements
- R1: After reset, `evt_flags` is 2'b00, `irq` is 0 and `wake_req` is 0.
- R2: A cycle with `alarm_hit` high sets `evt_flags[0]` (the alarm flag) at the next clock edge, whatever the enable bits are.
- R3: The divider counts `base_pulse` cycles from reset. With selector value s (0 to 7), every 2^(7-s)-th base pulse is a tick. This gives 2^s ticks per second from a 128 Hz base. A tick sets `evt_flags[1]` (the tick flag) at the next edge, whatever the enable bits are.
- R4: A cycle with `clr_wr` high clears each flag whose `clr_data` bit is 1 (bit 0 alarm, bit 1 tick) at the next edge. A `clr_data` bit of 0 leaves its flag unchanged.
- R5: When an event and a clear of the same flag fall in the same cycle, the flag is 1 after the edge.
- R6: `irq` is high exactly when (`evt_flags[0]` and `irq_en[0]`) or (`evt_flags[1]` and `irq_en[1]`). It follows flag and enable changes in the same cycle, with no added register.
- R7: With `pwr_down` high, an alarm raises `wake_req` at the next edge whether `tick_wake_en` is 0 or 1.
- R8: With `pwr_down` high, a tick raises `wake_req` at the next edge only when `tick_wake_en` is 1. With `tick_wake_en` 0, a tick does not raise it.
- R9: `wake_req` stays high while `pwr_down` is high. It is 0 from the edge after `pwr_down` falls. Events while `pwr_down` is low never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alarm_hit | input | 1 | Alarm-match pulse, one cycle |
| base_pulse | input | 1 | 128 Hz base-rate pulse, one cycle each |
| tick_sel | input | 3 | Tick rate selector, 2^value ticks per second |
| irq_en | input | 2 | Interrupt enables: bit 0 alarm, bit 1 tick |
| tick_wake_en | input | 1 | Allow ticks to wake from power-down |
| clr_wr | input | 1 | Flag clear write strobe |
| clr_data | input | 2 | Write-1-to-clear data: bit 0 alarm, bit 1 tick |
| pwr_down | input | 1 | Chip is in power-down |
| evt_flags | output | 2 | Sticky flags: bit 0 alarm, bit 1 tick |
| irq | output | 1 | Interrupt request |
| wake_req | output | 1 | Wake-up request level |

## Verification
Flags and the wake request are registered. Each becomes visible one clock edge after the cycle that carries its event, clear or power-down fall. `irq` is combinational from the registered flags and the enable inputs, so it is valid in the same cycle as any flag or enable change. The bench drives every input on the falling clock edge and samples at the following falling edge. It therefore always reads the state one rising edge after the stimulus, which is exactly when each registered result is due. The tick cases count base pulses from a fresh reset, so the pulse that produces the tick is known exactly.

// File: rtl/rtciw_pkg.sv
package rtciw_pkg;

    localparam int NUM_EVT   = 2;
    localparam int EVT_ALARM = 0;
    localparam int EVT_TICK  = 1;

    typedef enum logic [1:0] {
        WK_AWAKE  = 2'd0,
        WK_ASLEEP = 2'd1,
        WK_WAKING = 2'd2
    } wk_state_t;

endpackage

// File: rtl/rtciw_tick_div.sv
module rtciw_tick_div #(
    parameter int BASE_LOG2 = 7,
    parameter int SEL_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    localparam logic [BASE_LOG2-1:0] CNT_ONE = BASE_LOG2'(1);

    logic [BASE_LOG2-1:0] cnt_q;
    logic [BASE_LOG2-1:0] mask;

    // low (BASE_LOG2 - sel) counter bits must all be ones for a tick
    always_comb begin
        mask = '0;
        for (int i = 0; i < BASE_LOG2; i++) begin
            if (i < BASE_LOG2 - int'(sel_i)) begin
                mask[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (base_i) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign tick_o = base_i && ((cnt_q & mask) == mask);

    AST_TICK_NEEDS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> base_i);                                      // R3
    AST_FULL_RATE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (base_i && int'(sel_i) >= BASE_LOG2) |-> tick_o);        // R3

endmodule

// File: rtl/rtciw_flags.sv
module rtciw_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         clr_wr_i,
    input  logic [N-1:0] clr_data_i,
    output logic [N-1:0] flag_o
);

    logic [N-1:0] flag_q;

    for (genvar g = 0; g < N; g++) begin : g_flag
        logic clr_hit;
        assign clr_hit = clr_wr_i && clr_data_i[g];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[g] <= 1'b0;
            end else if (evt_i[g]) begin
                flag_q[g] <= 1'b1;
            end else if (clr_hit) begin
                flag_q[g] <= 1'b0;
            end
        end

        AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[g] |=> flag_q[g]);                             // R5
        AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_hit && !evt_i[g]) |=> !flag_q[g]);              // R4
        AST_FLAG_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag_q[g] && !evt_i[g]) |=> !flag_q[g]);           // R2
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/rtciw_wake_fsm.sv
module rtciw_wake_fsm
    import rtciw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down_i,
    input  logic alarm_i,
    input  logic tick_i,
    input  logic tick_wake_en_i,
    output logic wake_o
);

    wk_state_t state_q;
    wk_state_t state_d;
    logic      wake_evt;

    assign wake_evt = alarm_i || (tick_i && tick_wake_en_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WK_AWAKE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WK_AWAKE: begin
                if (pwr_down_i) begin
                    state_d = wake_evt ? WK_WAKING : WK_ASLEEP;
                end
            end
            WK_ASLEEP: begin
                if (!pwr_down_i) begin
                    state_d = WK_AWAKE;
                end else if (wake_evt) begin
                    state_d = WK_WAKING;
                end
            end
            WK_WAKING: begin
                if (!pwr_down_i) begin
                    state_d = WK_AWAKE;
                end
            end
            default: state_d = WK_AWAKE;
        endcase
    end

    always_comb begin
        wake_o = (state_q == WK_WAKING);
    end

    AST_ALARM_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down_i && alarm_i) |=> wake_o);                     // R7
    AST_TICK_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != WK_WAKING && !alarm_i && !tick_wake_en_i) |=> !wake_o); // R8
    AST_WAKE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && pwr_down_i) |=> wake_o);                      // R9
    AST_WAKE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_down_i |=> !wake_o);                                // R9

endmodule

// File: rtl/rtc_evt_wake_ctrl.sv
module rtc_evt_wake_ctrl
    import rtciw_pkg::*;
#(
    parameter int BASE_LOG2 = 7,
    parameter int SEL_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alarm_hit,
    input  logic                 base_pulse,
    input  logic [SEL_W-1:0]     tick_sel,
    input  logic [NUM_EVT-1:0]   irq_en,
    input  logic                 tick_wake_en,
    input  logic                 clr_wr,
    input  logic [NUM_EVT-1:0]   clr_data,
    input  logic                 pwr_down,
    output logic [NUM_EVT-1:0]   evt_flags,
    output logic                 irq,
    output logic                 wake_req
);

    logic               tick;
    logic [NUM_EVT-1:0] evt;

    rtciw_tick_div #(
        .BASE_LOG2 (BASE_LOG2),
        .SEL_W     (SEL_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .base_i (base_pulse),
        .sel_i  (tick_sel),
        .tick_o (tick)
    );

    always_comb begin
        evt            = '0;
        evt[EVT_ALARM] = alarm_hit;
        evt[EVT_TICK]  = tick;
    end

    rtciw_flags #(.N(NUM_EVT)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt),
        .clr_wr_i   (clr_wr),
        .clr_data_i (clr_data),
        .flag_o     (evt_flags)
    );

    assign irq = |(evt_flags & irq_en);

    rtciw_wake_fsm u_wake (
        .clk            (clk),
        .rst_n          (rst_n),
        .pwr_down_i     (pwr_down),
        .alarm_i        (alarm_hit),
        .tick_i         (tick),
        .tick_wake_en_i (tick_wake_en),
        .wake_o         (wake_req)
    );

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);                                // R6
    AST_ALARM_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> evt_flags[EVT_ALARM]);                     // R2

endmodule

// File: tb/test_rtc_evt_wake_ctrl.sv
module test_rtc_evt_wake_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alarm_hit = 1'b0;
    logic       base_pulse = 1'b0;
    logic [2:0] tick_sel = 3'd7;
    logic [1:0] irq_en = 2'b00;
    logic       tick_wake_en = 1'b0;
    logic       clr_wr = 1'b0;
    logic [1:0] clr_data = 2'b00;
    logic       pwr_down = 1'b0;
    logic [1:0] evt_flags;
    logic       irq;
    logic       wake_req;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    rtc_evt_wake_ctrl i_rtc_evt_wake_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .alarm_hit    (alarm_hit),
        .base_pulse   (base_pulse),
        .tick_sel     (tick_sel),
        .irq_en       (irq_en),
        .tick_wake_en (tick_wake_en),
        .clr_wr       (clr_wr),
        .clr_data     (clr_data),
        .pwr_down     (pwr_down),
        .evt_flags    (evt_flags),
        .irq          (irq),
        .wake_req     (wake_req)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        alarm_hit = 0; base_pulse = 0; clr_wr = 0; clr_data = 0;
        pwr_down = 0; tick_wake_en = 0; irq_en = 0; tick_sel = 3'd7;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // one-cycle pulses; each returns at the falling edge after the capturing edge
    task automatic pulse_alarm();
        alarm_hit = 1'b1;
        @(negedge clk);
        alarm_hit = 1'b0;
    endtask

    task automatic pulse_base();
        base_pulse = 1'b1;
        @(negedge clk);
        base_pulse = 1'b0;
    endtask

    task automatic write_clr(input logic [1:0] d);
        clr_wr = 1'b1;
        clr_data = d;
        @(negedge clk);
        clr_wr = 1'b0;
        clr_data = 2'b00;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 flags", int'(evt_flags), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 wake", int'(wake_req), 0);
    endtask

    task automatic t_alarm_flag();
        do_reset();
        irq_en = 2'b00;
        pulse_alarm();
        chk("R2 alarm flag with enables off", int'(evt_flags), 1);
        chk("R6 irq off with enables off", int'(irq), 0);
    endtask

    task automatic t_tick_rate(input logic [2:0] s);
        int n;
        do_reset();
        tick_sel = s;
        n = 1 << (7 - int'(s));
        for (int i = 1; i < n; i++) begin
            pulse_base();
        end
        chk("R3 no tick before divide count", int'(evt_flags[1]), 0);
        pulse_base();
        chk("R3 tick on divide count", int'(evt_flags[1]), 1);
    endtask

    task automatic t_clear();
        do_reset();
        pulse_alarm();
        pulse_base();
        chk("R3 both flags set", int'(evt_flags), 3);
        write_clr(2'b00);
        chk("R4 clear with zeros no effect", int'(evt_flags), 3);
        write_clr(2'b01);
        chk("R4 clear alarm only", int'(evt_flags), 2);
        write_clr(2'b10);
        chk("R4 clear tick", int'(evt_flags), 0);
    endtask

    task automatic t_event_wins();
        do_reset();
        alarm_hit = 1'b1;
        clr_wr = 1'b1;
        clr_data = 2'b01;
        @(negedge clk);
        alarm_hit = 1'b0;
        clr_wr = 1'b0;
        clr_data = 2'b00;
        chk("R5 alarm beats clear", int'(evt_flags), 1);
        base_pulse = 1'b1;
        clr_wr = 1'b1;
        clr_data = 2'b11;
        @(negedge clk);
        base_pulse = 1'b0;
        clr_wr = 1'b0;
        clr_data = 2'b00;
        chk("R5 tick beats clear, alarm cleared", int'(evt_flags), 2);
    endtask

    task automatic t_irq();
        do_reset();
        pulse_alarm();
        pulse_base();
        irq_en = 2'b00;
        #1 chk("R6 both flags no enable", int'(irq), 0);
        irq_en = 2'b01;
        #1 chk("R6 alarm enabled", int'(irq), 1);
        irq_en = 2'b10;
        #1 chk("R6 tick enabled", int'(irq), 1);
        @(negedge clk);
        write_clr(2'b10);
        chk("R6 tick cleared, tick enable only", int'(irq), 0);
        irq_en = 2'b01;
        #1 chk("R6 alarm flag still there", int'(irq), 1);
    endtask

    task automatic t_wake_alarm(input logic twe);
        do_reset();
        tick_wake_en = twe;
        pwr_down = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R7 no wake before event", int'(wake_req), 0);
        pulse_alarm();
        chk("R7 alarm wakes", int'(wake_req), 1);
        repeat (3) @(negedge clk);
        chk("R9 wake held", int'(wake_req), 1);
        pwr_down = 1'b0;
        @(negedge clk);
        chk("R9 wake released", int'(wake_req), 0);
    endtask

    task automatic t_wake_tick();
        do_reset();
        tick_sel = 3'd7;
        tick_wake_en = 1'b0;
        pwr_down = 1'b1;
        @(negedge clk);
        pulse_base();
        chk("R8 tick flag set while asleep", int'(evt_flags[1]), 1);
        chk("R8 tick without wake enable", int'(wake_req), 0);
        tick_wake_en = 1'b1;
        pulse_base();
        chk("R8 tick with wake enable", int'(wake_req), 1);
        pwr_down = 1'b0;
        @(negedge clk);
        chk("R9 released after tick wake", int'(wake_req), 0);
        pulse_alarm();
        chk("R9 alarm while awake no wake", int'(wake_req), 0);
        pulse_base();
        chk("R9 tick while awake no wake", int'(wake_req), 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_alarm_flag();
                t_tick_rate(3'd7);
                t_tick_rate(3'd5);
                t_tick_rate(3'd0);
                t_clear();
                t_event_wins();
                t_irq();
                t_wake_alarm(1'b0);
                t_wake_alarm(1'b1);
                t_wake_tick();
            end
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired got=0 exp=1");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule